// File: doc/BRIEF.md
# Successive-Approximation Converter Bus Controller

This block is the digital sequencer of an 8-bit successive-approximation analog-to-digital converter that a processor reaches like a memory location. The processor selects it with an active-low chip select. A write strobe starts a conversion. The block pulls an active-low interrupt when the result is ready. A read strobe then places the latched result on the data lines. An output-enable marks when those lines would be driven, in place of three-state buffers.

On the analog side, the block drives an 8-bit trial code to an external ladder DAC. Each clock it samples a one-bit comparator. The comparator reads 1 when the input is at or above the trial level. The bits are resolved from the MSB down. A conversion waits for a free-running 8-phase clock divider to wrap before its sequence begins. It then runs a fixed 65-clock sequence, so the time from start to interrupt lies between 66 and 73 clocks.

Wiring the interrupt back to the write strobe, with select and read held low, gives a free-running converter whose output follows the input.

Top module: `sar_bus_adc`

## Requirements
- R1: After the synchronous active-high reset, the interrupt output is 1, the trial code is 0x00, and a read returns 0x00.
- R2: While chip select is high, the read and write strobes have no effect: no conversion starts, a pending interrupt stays low, and the output-enable stays 0 with the data lines at 0x00.
- R3: While chip select and write are both low, the block is held idle: the trial code is 0x00, no conversion completes, and the interrupt cannot fall. A conversion that is running when this happens is abandoned.
- R4: A conversion starts on the clock edge that first samples write high after the write-active state. The interrupt falls between 66 and 73 clocks after that edge.
- R5: The result equals the input level clamped to 0..255, found by successive approximation. Bit 7 is the MSB. The comparator input at 1 means input >= trial code.
- R6: A falling edge of read or of write, with chip select low, returns a low interrupt to 1 on the next clock edge.
- R7: The output-enable is 1 exactly while chip select and read are both low. The data output then shows the latched result, and 0x00 otherwise.
- R8: A negative differential input, where every trial fails, gives the result 0x00.
- R9: The latched result changes only when a conversion ends. A read during a conversion returns the previous result.
- R10: With the interrupt tied to write and select and read held low, conversions repeat without further stimulus, and each one updates the data output.
- R11: The first nonzero trial code of a conversion is 0x80, so the MSB is tried first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; its release starts a conversion |
| cmp_ge | input | 1 | Comparator: 1 when the analog input is at or above the trial level |
| trial_code | output | 8 | Code presented to the external DAC |
| intr_n | output | 1 | End-of-conversion interrupt, active low |
| data_oe | output | 1 | High when the data lines would be driven |
| data_out | output | 8 | Latched result while enabled, 0x00 otherwise |

## Verification
A wrong bit decision shows at the ports within one clock. The trial code is the running approximation, so a kept or cleared bit is visible on the next cycle, and the final read exposes any wrong bit against the clamped input level. A stuck sequencer or a misaligned phase wait shows as an interrupt that falls outside the 66 to 73 clock window, or that never falls. A wrongly gated strobe shows within one clock as a cleared interrupt or as trial activity while the block is deselected. A latch updated at the wrong time shows as a mid-conversion read that no longer returns the previous value.

// File: rtl/sar_bus_adc.sv
module sar_bus_adc #(
  parameter int DATA_W    = 8,
  parameter int PHASES    = 8,
  parameter int SEQ_LEN   = 65,
  parameter int SAR_FIRST = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              cmp_ge,
  output logic [DATA_W-1:0] trial_code,
  output logic              intr_n,
  output logic              data_oe,
  output logic [DATA_W-1:0] data_out
);

  localparam int PH_W  = $clog2(PHASES);
  localparam int CNT_W = $clog2(SEQ_LEN + 1);
  localparam int LAT_W = $clog2(SEQ_LEN + PHASES + 2);
  localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(PHASES - 1);
  localparam logic [CNT_W-1:0]  SAR_LO   = CNT_W'(SAR_FIRST);
  localparam logic [CNT_W-1:0]  SAR_HI   = CNT_W'(SAR_FIRST + DATA_W);
  localparam logic [CNT_W-1:0]  SAR_ARM  = CNT_W'(SAR_FIRST - 1);
  localparam logic [CNT_W-1:0]  SEQ_END  = CNT_W'(SEQ_LEN - 1);
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [LAT_W-1:0]  LAT_MIN  = LAT_W'(SEQ_LEN + 1);
  localparam logic [LAT_W-1:0]  LAT_MAX  = LAT_W'(SEQ_LEN + PHASES);

  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_RUN} state_t;

  state_t            state;
  logic [PH_W-1:0]   phase;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] code, result;
  logic              intr_q, wr_act_q, rd_act_q;
  logic [LAT_W-1:0]  lat_q;

  wire wr_act = !cs_n && !wr_n;
  wire rd_act = !cs_n && !rd_n;
  wire start  = wr_act_q && !wr_act;
  wire clr    = (wr_act && !wr_act_q) || (rd_act && !rd_act_q);
  wire in_sar = (cnt >= SAR_LO) && (cnt < SAR_HI);

  logic [DATA_W-1:0] cur_bit, code_dec;
  always_comb begin
    cur_bit  = MSB_MASK >> (cnt - SAR_LO);
    code_dec = (cmp_ge ? code : (code & ~cur_bit)) | (cur_bit >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= '0;
      cnt      <= '0;
      code     <= '0;
      result   <= '0;
      intr_q   <= 1'b1;
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
    end else begin
      phase    <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      if (clr) intr_q <= 1'b1;
      if (wr_act) begin
        state <= ST_IDLE;
        code  <= '0;
      end else if (start) begin
        state <= ST_SYNC;
        code  <= '0;
      end else begin
        case (state)
          ST_SYNC: if (phase == PH_LAST) begin
            state <= ST_RUN;
            cnt   <= '0;
          end
          ST_RUN: begin
            cnt <= cnt + 1'b1;
            if (cnt == SAR_ARM) code <= MSB_MASK;
            else if (in_sar)    code <= code_dec;
            if (cnt == SEQ_END) begin
              result <= code;
              intr_q <= 1'b0;
              state  <= ST_IDLE;
              code   <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   lat_q <= '0;
    else if (start)            lat_q <= '0;
    else if (state != ST_IDLE) lat_q <= lat_q + 1'b1;
  end

  assign trial_code = code;
  assign intr_n     = intr_q;
  assign data_oe    = rd_act;
  assign data_out   = rd_act ? result : '0;

  initial begin
    assert (SAR_FIRST >= 1 && SAR_FIRST + DATA_W < SEQ_LEN);
  end

  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (intr_n && trial_code == '0 && result == '0)); // R1

  AST_DESEL_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $rose(intr_n) |-> ($past(rst) || !$past(cs_n))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n) |=> (trial_code == '0 && !$fell(intr_n))); // R3

  AST_LATENCY_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $fell(intr_n) |-> (lat_q >= LAT_MIN && lat_q <= LAT_MAX)); // R4

  AST_RESULT_AT_END: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> $fell(intr_n)); // R9

endmodule

// File: tb/tb_sar_bus_adc.sv
module tb_sar_bus_adc;
  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_drv = 1'b1, kick_n = 1'b1, free_mode = 1'b0;
  logic [7:0] trial_code, data_out;
  logic intr_n, data_oe, wr_n, cmp_ge;
  int vin = 0;
  int n_chk = 0, n_fail = 0, cyc = 0;

  localparam int NV = 10;
  localparam int VIN_TAB [NV] = '{0, 255, 128, 127, 1, 170, 85, 300, -20, 64};

  assign wr_n   = free_mode ? (intr_n & kick_n) : wr_drv;
  assign cmp_ge = (vin >= int'(trial_code));

  sar_bus_adc dut (.clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .cmp_ge(cmp_ge), .trial_code(trial_code), .intr_n(intr_n),
    .data_oe(data_oe), .data_out(data_out));

  always #10 clk = ~clk;

  function automatic int clamp8(input int v);
    return (v < 0) ? 0 : (v > 255) ? 255 : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic convert(input int v, output int lat, output int first);
    vin = v;
    @(negedge clk); cs_n = 0; wr_drv = 0;
    @(negedge clk); wr_drv = 1;
    lat = 0; first = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); lat++;
      if (first < 0 && trial_code != 0) first = int'(trial_code);
      if (intr_n == 0) break;
    end
    cs_n = 1;
  endtask

  task automatic do_read(output int val, output bit oe, output bit intr_after);
    @(negedge clk); cs_n = 0; rd_n = 0;
    #1 val = int'(data_out); oe = data_oe;
    @(negedge clk); intr_after = intr_n;
    rd_n = 1; cs_n = 1;
  endtask

  initial begin
    int lat, first, val, falls;
    bit oe, ia, ok;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(intr_n == 1, "R1 intr after reset", intr_n, 1);
    chk(trial_code == 0, "R1 trial after reset", trial_code, 0);
    chk(data_oe == 0, "R7 oe idle", data_oe, 0);
    do_read(val, oe, ia);
    chk(val == 0, "R1 read after reset", val, 0);
    chk(oe == 1, "R7 oe during read", oe, 1);

    for (int k = 0; k < NV; k++) begin
      convert(VIN_TAB[k], lat, first);
      chk(lat >= 66 && lat <= 73, "R4 latency", lat, 66);
      chk(first == 8'h80, "R11 first trial", first, 128);
      do_read(val, oe, ia);
      chk(val == clamp8(VIN_TAB[k]), "R5/R8 result", val, clamp8(VIN_TAB[k]));
      chk(ia == 1, "R6 read clears intr", ia, 1);
    end

    convert(42, lat, first);
    @(negedge clk); cs_n = 1; rd_n = 0; wr_drv = 0;
    #1 chk(data_oe == 0 && data_out == 0, "R2 deselected read", data_out, 0);
    @(negedge clk); wr_drv = 1;
    @(negedge clk); rd_n = 1;
    ok = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (intr_n != 0 || trial_code != 0) ok = 0;
    end
    chk(ok, "R2 strobes ignored when deselected", intr_n, 0);

    cs_n = 0; wr_drv = 0;
    @(negedge clk);
    chk(intr_n == 1, "R6 write clears intr", intr_n, 1);
    ok = 1;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (intr_n != 1 || trial_code != 0) ok = 0;
    end
    chk(ok, "R3 held idle while write low", trial_code, 0);
    vin = 200; wr_drv = 1;
    repeat (30) @(negedge clk);
    wr_drv = 0;
    @(negedge clk);
    chk(trial_code == 0, "R3 abort clears trial", trial_code, 0);
    ok = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (intr_n != 1) ok = 0;
    end
    chk(ok, "R3 aborted conversion never completes", intr_n, 1);
    wr_drv = 1; cs_n = 1;
    do_read(val, oe, ia);
    chk(val == 42, "R3 latch kept after abort", val, 42);

    convert(100, lat, first);
    do_read(val, oe, ia);
    vin = 200;
    @(negedge clk); cs_n = 0; wr_drv = 0;
    @(negedge clk); wr_drv = 1; cs_n = 1;
    repeat (20) @(negedge clk);
    do_read(val, oe, ia);
    chk(val == 100, "R9 read mid-conversion", val, 100);
    for (int i = 0; i < 100 && intr_n; i++) @(negedge clk);
    do_read(val, oe, ia);
    chk(val == 200, "R9 new result after end", val, 200);

    vin = 77; cs_n = 0; rd_n = 0; free_mode = 1; kick_n = 0;
    @(negedge clk); kick_n = 1;
    @(negedge clk); kick_n = 0;
    @(negedge clk); kick_n = 1;
    falls = 0;
    for (int i = 0; i < 500; i++) begin
      bit prev;
      prev = intr_n;
      @(negedge clk);
      if (prev && !intr_n) falls++;
    end
    chk(falls >= 6, "R10 free-running conversions", falls, 6);
    chk(data_out == 77, "R10 free-run result", data_out, 77);
    vin = 33;
    repeat (300) @(negedge clk);
    chk(data_out == 33, "R10 free-run tracks input", data_out, 33);
    free_mode = 0; rd_n = 1; cs_n = 1;
    repeat (5) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule